// File: doc/BRIEF.md
# Peak Channel Locator with Neighbourhood Walker

This block receives one event of channel energies from a square photodetector grid (8 by 8 by default). The energies arrive one per accepted valid/ready transfer, in row-major order. The block compares one sample per cycle and keeps the strongest channel seen so far. When the last channel of the event has been accepted, it reports the row and column of the peak.

The peak then sets the centre of a fixed neighbourhood for the likelihood datapath downstream. That neighbourhood is a 5 by 5 square with its four corner cells left out, which gives 21 cells. If the peak lies close to an edge of the grid, the centre is pulled inward on each axis so that the whole neighbourhood stays on the sensor. The block then walks the 21 cells one per cycle in row-major order. Each cell address is the centre plus a row offset and a column offset. A start strobe marks the cycle that opens a sum and an end strobe marks the cycle that closes it.

While the walk runs, the input is held off. A new event is taken as soon as the walk has ended.

Top module: `peak_mask_seq`

## Requirements
- R1: After reset, `in_ready` is 1, and `peak_done`, `cell_valid`, `cell_first` and `cell_last` are 0.
- R2: A sample is taken only in a cycle where `in_valid` and `in_ready` are both 1. The k-th sample taken in an event belongs to channel k, where k = row*8 + col (row-major). Cycles in which `in_valid` is 0 take no sample.
- R3: `peak_done` is 1 for exactly one cycle: the cycle after the 64th sample of an event is taken. From that cycle on, `peak_row` and `peak_col` give the channel with the highest energy. They hold until the first sample of the next event.
- R4: When several channels share the highest energy, the one with the lowest row-major index is reported.
- R5: The centre (`ctr_row`, `ctr_col`) is the peak with each coordinate clamped to the range 2..5. It is valid from the first cell of the walk and holds until the next `peak_done`.
- R6: The walk starts in the cycle after `peak_done`. `cell_valid` is 1 for exactly 21 consecutive cycles. Each cell equals the centre plus an offset (dr, dc), with dr and dc in -2..2, excluding the four pairs where both |dr| = 2 and |dc| = 2. Cells are visited with dr as the outer loop and dc as the inner loop, both ascending.
- R7: `cell_first` is 1 only on the first cell of the walk and `cell_last` is 1 only on the 21st cell. The cycle after `cell_last`, `cell_valid` is 0.
- R8: Every cell of the walk lies inside the 8 by 8 grid (row and column in 0..7).
- R9: `in_ready` is 0 from the `peak_done` cycle through the last cell of the walk. Samples offered during that time are not taken and do not affect any later result. `in_ready` returns to 1 in the cycle after `cell_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Energy sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_energy | input | 12 | Channel energy, unsigned |
| peak_done | output | 1 | One-cycle pulse: the peak search is complete |
| peak_row | output | 3 | Row of the peak channel |
| peak_col | output | 3 | Column of the peak channel |
| ctr_row | output | 3 | Clamped neighbourhood centre row |
| ctr_col | output | 3 | Clamped neighbourhood centre column |
| cell_valid | output | 1 | A neighbourhood cell is presented |
| cell_row | output | 3 | Row of the current cell |
| cell_col | output | 3 | Column of the current cell |
| cell_first | output | 1 | First cell of the walk |
| cell_last | output | 1 | Last cell of the walk |

## Verification
The assertions assume that the source never starts an event mid-stream. After reset, every group of 64 taken samples must form one event. The assertions also assume that `in_ready` is the only thing that gates intake, so any `in_valid` pattern is legal. The stimulus always sends complete events of 64 samples and inserts idle cycles between some of them. It keeps `in_valid` high with a maximal energy while the block is busy, which exercises the hold-off without breaking the event framing.

// File: rtl/peak_mask_pkg.sv
package peak_mask_pkg;

  // Clamp a coordinate into [lo, hi].
  function automatic int clamp_coord(input int p, input int lo, input int hi);
    if (p < lo) return lo;
    if (p > hi) return hi;
    return p;
  endfunction

  // Lowest column offset index (0..2r) allowed in offset row u.
  // The two outer rows lose their corner cells.
  function automatic int off_lo(input int u, input int r);
    return (u == 0 || u == 2 * r) ? 1 : 0;
  endfunction

  // Highest column offset index allowed in offset row u.
  function automatic int off_hi(input int u, input int r);
    return (u == 0 || u == 2 * r) ? 2 * r - 1 : 2 * r;
  endfunction

  // Cell coordinate from centre, radius and offset index.
  function automatic int cell_coord(input int c, input int r, input int off);
    return c - r + off;
  endfunction

  // Number of cells in a square of radius r with its four corners removed.
  function automatic int mask_cells(input int r);
    return (2 * r + 1) * (2 * r + 1) - 4;
  endfunction

endpackage

// File: rtl/peak_scan.sv
module peak_scan #(
  parameter int GRID = 8,
  parameter int EW   = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [EW-1:0]               energy,
  output logic                        done,
  output logic [$clog2(GRID)-1:0]     pk_row,
  output logic [$clog2(GRID)-1:0]     pk_col
);
  localparam int N  = GRID * GRID;
  localparam int IW = $clog2(N);
  localparam int RW = $clog2(GRID);

  logic [IW-1:0] idx;
  logic [IW-1:0] best_idx;
  logic [EW-1:0] best_e;
  logic          last_take;
  logic          better;

  assign last_take = take && (idx == IW'(N - 1));
  // Strict compare: an equal later channel never replaces the stored one.
  assign better    = (idx == '0) || (energy > best_e);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      best_idx <= '0;
      best_e   <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_take;
      if (take) begin
        idx <= last_take ? '0 : idx + 1'b1;
        if (better) begin
          best_e   <= energy;
          best_idx <= idx;
        end
      end
    end
  end

  assign pk_row = RW'(int'(best_idx) / GRID);
  assign pk_col = RW'(int'(best_idx) % GRID);

  // R3: done is a single-cycle pulse.
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: done follows a completed event, so the channel counter has wrapped.
  assert_done_wrapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idx == '0);
endmodule

// File: rtl/mask_walker.sv
module mask_walker
  import peak_mask_pkg::*;
#(
  parameter int GRID = 8,
  parameter int R    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [$clog2(GRID)-1:0] pk_row,
  input  logic [$clog2(GRID)-1:0] pk_col,
  output logic [$clog2(GRID)-1:0] ctr_row,
  output logic [$clog2(GRID)-1:0] ctr_col,
  output logic                    active,
  output logic [$clog2(GRID)-1:0] cell_row,
  output logic [$clog2(GRID)-1:0] cell_col,
  output logic                    first,
  output logic                    last
);
  localparam int RW    = $clog2(GRID);
  localparam int OW    = $clog2(2 * R + 1);
  localparam int CELLS = mask_cells(R);
  localparam int LO    = R;
  localparam int HI    = GRID - 1 - R;

  logic [OW-1:0] u;  // row offset index 0..2R
  logic [OW-1:0] v;  // column offset index 0..2R
  logic          row_end;

  assign row_end = (int'(v) == off_hi(int'(u), R));
  assign first   = active && (u == '0) && (int'(v) == off_lo(0, R));
  assign last    = active && (int'(u) == 2 * R) && row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      u       <= '0;
      v       <= '0;
      ctr_row <= '0;
      ctr_col <= '0;
    end else if (start) begin
      active  <= 1'b1;
      u       <= '0;
      v       <= OW'(off_lo(0, R));
      ctr_row <= RW'(clamp_coord(int'(pk_row), LO, HI));
      ctr_col <= RW'(clamp_coord(int'(pk_col), LO, HI));
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
      end else if (row_end) begin
        u <= u + 1'b1;
        v <= OW'(off_lo(int'(u) + 1, R));
      end else begin
        v <= v + 1'b1;
      end
    end
  end

  assign cell_row = RW'(cell_coord(int'(ctr_row), R, int'(u)));
  assign cell_col = RW'(cell_coord(int'(ctr_col), R, int'(v)));

  // Independent count of walk cycles, for the length check.
  logic [$clog2(CELLS+1)-1:0] walk_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || start) walk_cnt <= '0;
    else if (active)     walk_cnt <= walk_cnt + 1'b1;
  end

  // R6: the end strobe comes on exactly the last of the cells.
  assert_walk_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> walk_cnt == ($clog2(CELLS+1))'(CELLS - 1));
  // R6: no corner offset is ever presented.
  assert_no_corner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !((u == '0 || int'(u) == 2 * R) && (v == '0 || int'(v) == 2 * R)));
  // R5: the centre stays in the clamp range while walking.
  assert_ctr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(ctr_row) >= LO && int'(ctr_row) <= HI &&
                int'(ctr_col) >= LO && int'(ctr_col) <= HI));
  // R7: start and end strobes are exclusive.
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(first && last));
endmodule

// File: rtl/peak_mask_seq.sv
module peak_mask_seq #(
  parameter int GRID = 8,
  parameter int EW   = 12,
  parameter int R    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [EW-1:0]           in_energy,
  output logic                    peak_done,
  output logic [$clog2(GRID)-1:0] peak_row,
  output logic [$clog2(GRID)-1:0] peak_col,
  output logic [$clog2(GRID)-1:0] ctr_row,
  output logic [$clog2(GRID)-1:0] ctr_col,
  output logic                    cell_valid,
  output logic [$clog2(GRID)-1:0] cell_row,
  output logic [$clog2(GRID)-1:0] cell_col,
  output logic                    cell_first,
  output logic                    cell_last
);
  logic take;
  logic busy;

  assign busy     = peak_done || cell_valid;
  assign in_ready = !busy;
  assign take     = in_valid && in_ready;

  peak_scan #(.GRID(GRID), .EW(EW)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .energy (in_energy),
    .done   (peak_done),
    .pk_row (peak_row),
    .pk_col (peak_col)
  );

  mask_walker #(.GRID(GRID), .R(R)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (peak_done),
    .pk_row   (peak_row),
    .pk_col   (peak_col),
    .ctr_row  (ctr_row),
    .ctr_col  (ctr_col),
    .active   (cell_valid),
    .cell_row (cell_row),
    .cell_col (cell_col),
    .first    (cell_first),
    .last     (cell_last)
  );

  // R6: the walk opens in the cycle after the peak is found.
  assert_walk_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_done |=> (cell_valid && cell_first));
  // R7: the walk stops right after its end strobe.
  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cell_last |=> !cell_valid);
  // R9: intake is held off for the whole walk.
  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_done || cell_valid) |-> !in_ready);
  // R8: each cell stays within the neighbourhood of the centre.
  assert_cell_near_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> (int'(cell_row) + R >= int'(ctr_row) && int'(cell_row) <= int'(ctr_row) + R &&
                    int'(cell_col) + R >= int'(ctr_col) && int'(cell_col) <= int'(ctr_col) + R));
endmodule

// File: tb/peak_mask_seq_test.sv
`timescale 1ns/1ps
module peak_mask_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_energy = '0;
  logic        peak_done;
  logic [2:0]  peak_row, peak_col, ctr_row, ctr_col, cell_row, cell_col;
  logic        cell_valid, cell_first, cell_last;

  int errors = 0;
  int checks = 0;
  logic [11:0] ev [64];

  always #2 clk = ~clk;

  peak_mask_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_energy(in_energy), .peak_done(peak_done), .peak_row(peak_row),
    .peak_col(peak_col), .ctr_row(ctr_row), .ctr_col(ctr_col),
    .cell_valid(cell_valid), .cell_row(cell_row), .cell_col(cell_col),
    .cell_first(cell_first), .cell_last(cell_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(cell_valid == 1'b0, "R1 cell_valid", int'(cell_valid), 0);
    chk(peak_done == 1'b0, "R1 done", int'(peak_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && !cell_valid && !cell_first && !cell_last, "R1 idle", int'(in_ready), 1);
  endtask

  // Send ev[], optionally with idle gaps and with valid held during the walk,
  // then check the peak, the centre and all 21 cells.
  task automatic run_event(input string name, input bit gaps, input bit hold_busy);
    int bi, er, ec, cr, cc, k;
    bi = 0;
    for (int i = 1; i < 64; i++) if (ev[i] > ev[bi]) bi = i;  // R4 lowest index on tie
    er = bi / 8; ec = bi % 8;
    cr = (er < 2) ? 2 : (er > 5 ? 5 : er);
    cc = (ec < 2) ? 2 : (ec > 5 ? 5 : ec);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_energy = ev[i];
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0; in_energy = 12'hFFF;  // R2 not taken
      end
    end
    @(negedge clk);
    in_valid = hold_busy; in_energy = 12'hFFF;
    chk(peak_done == 1'b1, {"R3 done ", name}, int'(peak_done), 1);
    chk(int'(peak_row) == er, {"R3 row ", name}, int'(peak_row), er);
    chk(int'(peak_col) == ec, {"R3 col ", name}, int'(peak_col), ec);
    chk(in_ready == 1'b0, {"R9 ready at done ", name}, int'(in_ready), 0);
    k = 0;
    for (int dr = -2; dr <= 2; dr++) begin
      for (int dc = -2; dc <= 2; dc++) begin
        if ((dr == 2 || dr == -2) && (dc == 2 || dc == -2)) continue;
        @(negedge clk);
        chk(cell_valid == 1'b1, {"R6 valid ", name}, int'(cell_valid), 1);
        chk(int'(cell_row) == cr + dr && int'(cell_col) == cc + dc, {"R6 cell ", name},
            int'(cell_row) * 8 + int'(cell_col), (cr + dr) * 8 + cc + dc);
        chk(cell_row <= 3'd7 && cell_col <= 3'd7 && cr + dr >= 0 && cc + dc >= 0,
            {"R8 inside ", name}, int'(cell_row), cr + dr);
        chk(int'(ctr_row) == cr && int'(ctr_col) == cc, {"R5 centre ", name},
            int'(ctr_row) * 8 + int'(ctr_col), cr * 8 + cc);
        chk(cell_first == (k == 0), {"R7 first ", name}, int'(cell_first), int'(k == 0));
        chk(cell_last == (k == 20), {"R7 last ", name}, int'(cell_last), int'(k == 20));
        chk(in_ready == 1'b0, {"R9 ready busy ", name}, int'(in_ready), 0);
        k++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(cell_valid == 1'b0, {"R7 end ", name}, int'(cell_valid), 0);
    chk(in_ready == 1'b1, {"R9 ready back ", name}, int'(in_ready), 1);
    chk(int'(peak_row) == er && int'(peak_col) == ec, {"R3 hold ", name},
        int'(peak_row) * 8 + int'(peak_col), bi);
  endtask

  task automatic t_centre_peak();
    for (int i = 0; i < 64; i++) ev[i] = 12'(100 + i % 7);
    ev[3 * 8 + 4] = 12'd900;
    run_event("centre", 1'b0, 1'b0);
  endtask

  task automatic t_corner_low();
    for (int i = 0; i < 64; i++) ev[i] = 12'(64 - i);
    ev[0] = 12'd2000;
    run_event("corner00", 1'b1, 1'b0);
  endtask

  task automatic t_edge_high();
    for (int i = 0; i < 64; i++) ev[i] = 12'(i * 3);
    ev[7 * 8 + 6] = 12'd3000;
    run_event("edge76", 1'b0, 1'b1);  // R9 held valid during walk
  endtask

  task automatic t_tie();
    for (int i = 0; i < 64; i++) ev[i] = 12'd50;
    ev[1 * 8 + 6] = 12'd700;  // R4 lower index wins
    ev[6 * 8 + 1] = 12'd700;
    ev[7 * 8 + 7] = 12'd700;
    run_event("tie", 1'b1, 1'b0);
  endtask

  task automatic t_after_hold();
    // R9: the event after a held-off walk must be framed correctly.
    for (int i = 0; i < 64; i++) ev[i] = 12'd10;
    ev[5 * 8 + 0] = 12'd11;
    run_event("afterhold", 1'b0, 1'b1);
    for (int i = 0; i < 64; i++) ev[i] = 12'((i * 37) % 61);
    run_event("scatter", 1'b1, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_centre_peak();
    t_corner_low();
    t_edge_high();
    t_tie();
    t_after_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule